// File: doc/BRIEF.md
# Key-Gated Watchdog Interval Timer

This block is a watchdog timer driven through two 16-bit registers on a simple register bus. The bus has one address bit, a write strobe, write data and combinational read data. The first register, the guard register, holds an unlock bit and reports a sticky expiry flag. The second register, the watchdog configuration register, holds these fields:

- a run-enable bit
- a two-bit interval select
- a backup-battery enable bit
- a write-only charge-enable bit
- a self-clearing kick (clear) command

Software first sets the unlock bit. It then programs the watchdog and kicks it at regular intervals. If no kick arrives before the selected interval runs out, the expiry flag sets and stays set. On the cycle the flag first sets, a single-cycle pulse is also driven out.

The time base is a prescaler of `PRESCALE_DIV` clock cycles. The four interval codes select 1, 2, 4 or 8 times `BASE_TICKS` prescaler ticks. The kick is the only write to the configuration register that always takes effect. Every other field in that register changes only while the unlock bit is set.

Top module: `wdt_keyed_top`

## Requirements
- R1: After a synchronous active-low reset, both registers read zero, the expiry flag and pulse are low, and the battery and charge outputs are low.
- R2: A write to address 0 loads the unlock bit from data bit 15. A read of address 0 returns the unlock bit in bit 15 and the expiry flag in bit 14, with all other bits zero.
- R3: A write to address 1 made while the unlock bit is clear leaves the enable, interval, battery and charge fields unchanged.
- R4: A write to address 1 with data bit 15 set restarts the elapsed time from zero and clears the expiry flag, whatever the state of the unlock bit.
- R5: Time advances only while the enable bit (bit 2 of address 1) is set. While it is clear, the elapsed time is held at zero, and an expiry flag that is already set stays set.
- R6: Interval code n in bits 1:0 of address 1 makes the flag set after exactly (BASE_TICKS << n) * PRESCALE_DIV enabled clock cycles, counted from the write that enabled or kicked the timer.
- R7: The expiry flag is sticky. It is cleared only by a kick or by reset.
- R8: The expiry pulse is high for exactly one cycle, namely the first cycle in which the flag reads as set. It does not fire again while the flag stays set.
- R9: A read of address 1 returns battery enable in bit 3, enable in bit 2 and the interval in bits 1:0. Bits 15 (kick) and 14 (charge) read as zero.
- R10: The battery output follows the stored bit 3. The charge output follows the stored write-only bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 is the guard register, 1 is the configuration register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| wdt_expired | output | 1 | Sticky expiry flag |
| wdt_expire_pulse | output | 1 | One-cycle pulse when the flag first sets |
| batt_en | output | 1 | Stored backup-battery enable |
| charge_en | output | 1 | Stored charge enable |

## Verification
The bench attacks the gate between the unlock bit and the configuration fields. A design that tests the new unlock value instead of the stored one, or that blocks the kick while locked, diverges from the model on the very next cycle.

The expiry point is checked on the exact cycle for several interval codes. An off-by-one in the prescaler or the terminal count shows up as a flag that sets one cycle early or one tick late.

Disabling the timer after expiry checks that the flag survives the disable. Waiting past a second full interval checks that the pulse does not fire again.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg: register field positions and the stored configuration
// type shared by the register file and the top level.
package wdt_pkg;
    localparam int REG_W      = 16;
    localparam int BIT_UNLOCK = 15;  // guard register: unlock bit
    localparam int BIT_FLAG   = 14;  // guard register: expiry flag on read
    localparam int BIT_KICK   = 15;  // config register: kick command
    localparam int BIT_CHARGE = 14;  // config register: charge enable (write-only)
    localparam int BIT_BATT   = 3;
    localparam int BIT_EN     = 2;

    typedef struct packed {
        logic       charge;
        logic       batt;
        logic       en;
        logic [1:0] intv;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
// Module wdt_prescaler: divides the clock into one tick every DIV cycles
// while run is high.
// Assumes restart and !run both return the phase to zero, so that a kick
// or a re-enable starts a full period.
module wdt_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign tick = run && (phase == LAST);

    // Advance the phase while running and wrap it on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            phase <= '0;
        else if (tick)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // With a divider above one, two ticks never fall on back-to-back cycles.
    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && DIV > 1) |=> !tick);
endmodule

// File: rtl/wdt_counter.sv
// Module wdt_counter: counts prescaler ticks against a terminal count
// selected by the interval code, and raises a sticky expiry flag together
// with a one-cycle pulse.
// Assumes kick has priority over expiry and that disabling the timer
// does not clear the flag.
module wdt_counter #(
    parameter int BASE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       kick,
    input  logic       tick,
    input  logic [1:0] intv,
    output logic       flag,
    output logic       pulse
);
    localparam int CW = $clog2(BASE_TICKS * 8) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] term_m1;
    logic          hit;

    assign term_m1 = (CW'(BASE_TICKS) << intv) - 1'b1;
    assign hit     = run && tick && (cnt >= term_m1);

    // Tick count: held at zero while stopped or kicked, wraps at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || kick || !run)
            cnt <= '0;
        else if (hit)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // Sticky flag plus the pulse on its first setting.
    always_ff @(posedge clk) begin
        if (!rst_n || kick) begin
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= hit && !flag;
            if (hit)
                flag <= 1'b1;
        end
    end

    assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0) && !flag);
    assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick) |=> (cnt == '0) && (flag == $past(flag)));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !kick) |=> flag);
    assert_pulse_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);
    assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/wdt_regfile.sv
// Module wdt_regfile: holds the guard and configuration registers, applies
// the unlock gate and forms the read data.
// Assumes the stored unlock value, not the one written in the same cycle,
// gates a configuration write, and that the kick is never gated.
module wdt_regfile
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             flag,
    output wdt_cfg_t         cfg,
    output logic             kick,
    output logic [REG_W-1:0] bus_rdata
);
    logic     unlock;
    logic     wr_guard;
    logic     wr_cfg;
    wdt_cfg_t cfg_next;

    assign wr_guard = bus_wr && !bus_addr;
    assign wr_cfg   = bus_wr && bus_addr;
    assign kick     = wr_cfg && bus_wdata[BIT_KICK];

    // Gather the configuration fields from the write data.
    always_comb begin
        cfg_next.charge = bus_wdata[BIT_CHARGE];
        cfg_next.batt   = bus_wdata[BIT_BATT];
        cfg_next.en     = bus_wdata[BIT_EN];
        cfg_next.intv   = bus_wdata[1:0];
    end

    // Guard register: the unlock bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlock <= 1'b0;
        else if (wr_guard)
            unlock <= bus_wdata[BIT_UNLOCK];
    end

    // Configuration register, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr_cfg && unlock)
            cfg <= cfg_next;
    end

    // Read mux; kick and charge never read back.
    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[BIT_UNLOCK] = unlock;
            bus_rdata[BIT_FLAG]   = flag;
        end else begin
            bus_rdata[BIT_BATT] = cfg.batt;
            bus_rdata[BIT_EN]   = cfg.en;
            bus_rdata[1:0]      = cfg.intv;
        end
    end

    assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !unlock) |=> $stable(cfg));
    assert_guard_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_guard |=> (unlock == $past(bus_wdata[BIT_UNLOCK])));
endmodule

// File: rtl/wdt_keyed_top.sv
// Module wdt_keyed_top: watchdog timer with a key-gated configuration
// register. It connects the register file, the tick prescaler and the
// interval counter.
// Assumes a single clock domain and combinational read data.
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int PRESCALE_DIV = 1000,
    parameter int BASE_TICKS   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        wdt_expired,
    output logic        wdt_expire_pulse,
    output logic        batt_en,
    output logic        charge_en
);
    wdt_cfg_t cfg;
    logic     kick;
    logic     tick;

    wdt_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (wdt_expired),
        .cfg       (cfg),
        .kick      (kick),
        .bus_rdata (bus_rdata)
    );

    wdt_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg.en),
        .restart (kick),
        .tick    (tick)
    );

    wdt_counter #(.BASE_TICKS(BASE_TICKS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg.en),
        .kick  (kick),
        .tick  (tick),
        .intv  (cfg.intv),
        .flag  (wdt_expired),
        .pulse (wdt_expire_pulse)
    );

    assign batt_en   = cfg.batt;
    assign charge_en = cfg.charge;
endmodule

// File: tb/wdt_keyed_top_tb.sv
// Bench for wdt_keyed_top: a behavioural reference model that counts
// elapsed enabled cycles, compared against the design on every clock.
module wdt_keyed_top_tb;
    localparam int DIV  = 2;
    localparam int BASE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdt_expired, wdt_expire_pulse, batt_en, charge_en;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // Reference model state.
    bit m_unlock, m_en, m_batt, m_charge, m_flag, m_pulse;
    bit [1:0] m_intv;
    int m_elapsed;

    wdt_keyed_top #(.PRESCALE_DIV(DIV), .BASE_TICKS(BASE)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_wr           (bus_wr),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .wdt_expired      (wdt_expired),
        .wdt_expire_pulse (wdt_expire_pulse),
        .batt_en          (batt_en),
        .charge_en        (charge_en)
    );

    always #4 clk = ~clk;  // 125 MHz

    function automatic bit [15:0] model_read(bit a);
        if (!a) return {m_unlock, m_flag, 14'b0};
        return {12'b0, m_batt, m_en, m_intv};
    endfunction

    // Model update from the inputs held across the edge.
    always @(posedge clk) begin
        bit old_unlock, old_en, set;
        old_unlock = m_unlock;
        old_en = m_en;
        if (!rst_n) begin
            m_unlock = 0; m_en = 0; m_batt = 0; m_charge = 0;
            m_flag = 0; m_pulse = 0; m_intv = 0; m_elapsed = 0;
        end else begin
            set = 0;
            if (bus_wr && bus_addr && bus_wdata[15]) begin   // R4
                m_elapsed = 0; m_flag = 0; m_pulse = 0;
            end else begin
                if (old_en) begin
                    m_elapsed++;
                    if (m_elapsed == (BASE << m_intv) * DIV) begin   // R6
                        set = 1; m_elapsed = 0;
                    end
                end else m_elapsed = 0;                        // R5
                m_pulse = set && !m_flag;                     // R8
                if (set) m_flag = 1;
            end
            if (bus_wr && !bus_addr) m_unlock = bus_wdata[15]; // R2
            if (bus_wr && bus_addr && old_unlock) begin        // R3
                m_en = bus_wdata[2]; m_intv = bus_wdata[1:0];
                m_batt = bus_wdata[3]; m_charge = bus_wdata[14];
            end
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare outputs at mid-cycle on every clock.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R9 model read", bus_rdata, model_read(bus_addr));
            check("R7 model flag", 16'(wdt_expired), 16'(m_flag));
            check("R8 model pulse", 16'(wdt_expire_pulse), 16'(m_pulse));
            check("R10 model batt", 16'(batt_en), 16'(m_batt));
            check("R10 model charge", 16'(charge_en), 16'(m_charge));
        end
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(bit a, logic [15:0] d);
        @(posedge clk); #2;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic peek(bit a, string req, logic [15:0] exp);
        bus_addr = a;
        @(negedge clk);
        check(req, bus_rdata, exp);
        #1;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        peek(0, "R1 guard reset", 16'h0000);
        peek(1, "R1 cfg reset", 16'h0000);
        check("R1 flag reset", 16'(wdt_expired), 16'h0);
        // R3: locked write ignored
        wr(1, 16'h400D);
        peek(1, "R3 locked write", 16'h0000);
        check("R3 charge unchanged", 16'(charge_en), 16'h0);
        // R2: unlock
        wr(0, 16'h8000);
        peek(0, "R2 unlock readback", 16'h8000);
        // R9/R10: enable, interval 1, batt, charge
        wr(1, 16'h400D);
        peek(1, "R9 cfg readback", 16'h000D);
        check("R10 charge out", 16'(charge_en), 16'h1);
        // R6: interval 1 = 12 cycles from the write edge
        idle(10);
        check("R6 not yet expired", 16'(wdt_expired), 16'h0);
        idle(3);
        check("R6 expired", 16'(wdt_expired), 16'h1);
        peek(0, "R7 flag in guard", 16'hC000);
        idle(30);
        check("R7 still set", 16'(wdt_expired), 16'h1);
        // R4: relock, then kick clears
        wr(0, 16'h0000);
        wr(1, 16'h8000);
        peek(0, "R4 kick while locked", 16'h0000);
        peek(1, "R4 cfg kept", 16'h000D);
        // R5: expire, then disable keeps flag
        idle(14);
        wr(0, 16'h8000);
        wr(1, 16'h0000);
        idle(40);
        check("R5 flag held disabled", 16'(wdt_expired), 16'h1);
        // R6: other interval codes, each kicked then run to expiry
        for (int n = 0; n < 4; n++) begin
            wr(1, 16'h8004 | 16'(n));
            idle((BASE << n) * DIV + 4);
            check("R6 interval expiry", 16'(wdt_expired), 16'h1);
        end
        // R1: reset returns everything to zero
        @(posedge clk); #2; rst_n = 0;
        idle(2); rst_n = 1; idle(1);
        peek(1, "R1 cfg after reset", 16'h0000);
        check("R1 batt after reset", 16'(batt_en), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule